// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block holds a small bank of on-chip configuration registers behind two byte-wide I/O addresses. A write to the index address picks a register number. The next access to the data address then reads or writes that register. The block watches a simple I/O bus: an address, single-cycle read and write strobes, and 8-bit write and read data. It drives a combinational claim output in the same cycle as the strobe. A claimed cycle is answered on chip. Every unclaimed cycle is left to go out as an external I/O cycle.

Control register three carries two gating bits. Bit 4 is a map enable: it widens the set of register numbers the block answers. Bit 0 is a lock: it write-protects several control and address registers. A privileged-mode input overrides the lock. Each index write is good for exactly one data access. After that access the data address falls through to external cycles until the index is written again.

Top module: `cfg_index_port`

## Requirements
- R1: After reset, C1h, C2h, C3h and CDh–CFh read 00h. With map enable set, E8h reads 85h, 20h reads 07h, and EBh, B0h–B3h and B8h read 00h.
- R2: A write to the index address (default 22h) latches the data byte as the selected index. A claimed read at the data address (default 23h) returns the selected register in the same cycle. A claimed write updates it at the clock edge.
- R3: After any data-address access, claimed or not, the index is spent. Later data-address accesses are unclaimed until the next index write. A data access made before any index write since reset is also unclaimed.
- R4: While map enable (bit 4 of C3h) is 0, data accesses are claimed only for indexes C0h–CFh, FEh and FFh.
- R5: While map enable is 1, indexes E8h, EBh, 20h, B0h–B3h and B8h are also claimed and act as read/write registers.
- R6: While the lock (bit 0 of C3h) is 1 and the privileged input is low, writes to C1h, C3h and CDh–CFh are claimed but leave those registers unchanged, and reads return the held value. C2h stays writable.
- R7: While the privileged input is high, the lock has no effect, and writes to the lock-controlled registers take effect.
- R8: FEh always reads 40h. FFh reads the DEV_ID1 parameter. Writes to either are claimed and leave the value read back unchanged.
- R9: An index-address write is unclaimed while map enable is 0 and claimed while it is 1. In both cases the index is latched.
- R10: Indexes in C0h–CFh with no register behind them are claimed, read 00h, and keep reading 00h after a write.
- R11: Accesses to any other address, and reads of the index address, are unclaimed. Read data is 00h in every cycle that is not a claimed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | ADDR_W | I/O address of the current cycle |
| ioRd | input | 1 | Read strobe, one cycle per access |
| ioWr | input | 1 | Write strobe, one cycle per access |
| ioWrData | input | 8 | Write data |
| privMode | input | 1 | Privileged mode; overrides the write lock |
| ioRdData | output | 8 | Read data, 00h unless a claimed read |
| ioClaim | output | 1 | High when the block answers the current cycle |

## Verification
The bench uses the default ports 22h and 23h and sets DEV_ID1 to 2Ah. With these values, all 256 index values can be swept in every gating state: map enable clear and set, lock clear and set, and the privileged override. Each index is followed by a second, spent data access. Expected claim and read values come from a bench-side model built only from the listed index sets and reset values.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  localparam int DW         = 8;
  localparam int NUM_SMADDR = 3;
  localparam int NUM_HDR    = 4;
  localparam int MAPEN_BIT  = 4;
  localparam int LOCK_BIT   = 0;

  localparam logic [DW-1:0] RST_CTRL4 = 8'h85;
  localparam logic [DW-1:0] RST_PERF  = 8'h07;
  localparam logic [DW-1:0] ID0_VALUE = 8'h40;

  typedef enum logic [3:0] {
    REG_UNDEF, REG_CTRL1, REG_CTRL2, REG_CTRL3, REG_SMADDR,
    REG_CTRL4, REG_CTRL7, REG_PERF, REG_HDR, REG_GFX, REG_ID0, REG_ID1
  } regId_e;

  typedef struct packed {
    logic       hit;
    regId_e     id;
    logic [1:0] sub;
  } decode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       wrEn;
    logic       rdEn;
    regId_e     sel;
    logic [1:0] sub;
  } strobe_t;

  function automatic decode_t decodeIndex(input logic [7:0] idx, input logic mapEn);
    decode_t d;
    d.hit = 1'b0;
    d.id  = REG_UNDEF;
    d.sub = 2'd0;
    if (idx[7:4] == 4'hC) begin
      d.hit = 1'b1;
      case (idx)
        8'hC1: d.id = REG_CTRL1;
        8'hC2: d.id = REG_CTRL2;
        8'hC3: d.id = REG_CTRL3;
        8'hCD, 8'hCE, 8'hCF: begin
          d.id  = REG_SMADDR;
          d.sub = idx[1:0] - 2'd1;
        end
        default: d.id = REG_UNDEF;
      endcase
    end else if (idx == 8'hFE) begin
      d.hit = 1'b1;
      d.id  = REG_ID0;
    end else if (idx == 8'hFF) begin
      d.hit = 1'b1;
      d.id  = REG_ID1;
    end else if (mapEn) begin
      case (idx)
        8'hE8: begin d.hit = 1'b1; d.id = REG_CTRL4; end
        8'hEB: begin d.hit = 1'b1; d.id = REG_CTRL7; end
        8'h20: begin d.hit = 1'b1; d.id = REG_PERF;  end
        8'hB8: begin d.hit = 1'b1; d.id = REG_GFX;   end
        8'hB0, 8'hB1, 8'hB2, 8'hB3: begin
          d.hit = 1'b1;
          d.id  = REG_HDR;
          d.sub = idx[1:0];
        end
        default: d.hit = 1'b0;
      endcase
    end
    return d;
  endfunction

  function automatic logic isWritable(input regId_e id);
    return !(id == REG_UNDEF || id == REG_ID0 || id == REG_ID1);
  endfunction

  function automatic logic isLockable(input regId_e id);
    return (id == REG_CTRL1) || (id == REG_CTRL3) || (id == REG_SMADDR);
  endfunction

endpackage

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int unsigned INDEX_PORT = 'h22,
  parameter int unsigned DATA_PORT  = 'h23
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic [DW-1:0]     ioWrData,
  input  logic              privMode,
  input  logic              mapEn,
  input  logic              lockBit,
  output logic              ioClaim,
  output strobe_t           strb
);

  localparam logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(INDEX_PORT);
  localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(DATA_PORT);

  logic [7:0] idxReg;
  logic       idxValid;
  logic       idxWr;
  logic       dataAcc;
  logic       dataClaim;
  logic       wrBlocked;
  decode_t    dec;

  assign idxWr   = ioWr && (ioAddr == IDX_ADDR);
  assign dataAcc = (ioRd || ioWr) && (ioAddr == DAT_ADDR);
  assign dec     = decodeIndex(idxReg, mapEn);

  assign dataClaim = dataAcc && idxValid && dec.hit;
  assign ioClaim   = (idxWr && mapEn) || dataClaim;

  assign wrBlocked = isLockable(dec.id) && lockBit && !privMode;

  always_comb begin
    strb.wrEn = dataClaim && ioWr && isWritable(dec.id) && !wrBlocked;
    strb.rdEn = dataClaim && ioRd;
    strb.sel  = dec.id;
    strb.sub  = dec.sub;
  end

  // index latch and single-use valid flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg   <= 8'h00;
      idxValid <= 1'b0;
    end else if (idxWr) begin
      idxReg   <= ioWrData;
      idxValid <= 1'b1;
    end else if (dataAcc) begin
      idxValid <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_pkg::*;
#(
  parameter logic [7:0] DEV_ID1 = 8'h2A
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          mapEn,
  output logic          lockBit
);

  logic [DW-1:0] ctrl1, ctrl2, ctrl3, ctrl4, ctrl7, perf, gfx;
  logic [DW-1:0] smAddr [NUM_SMADDR];
  logic [DW-1:0] hdr    [NUM_HDR];
  logic [DW-1:0] selVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrl1 <= '0;
      ctrl2 <= '0;
      ctrl3 <= '0;
      ctrl4 <= RST_CTRL4;
      ctrl7 <= '0;
      perf  <= RST_PERF;
      gfx   <= '0;
    end else if (strb.wrEn) begin
      case (strb.sel)
        REG_CTRL1: ctrl1 <= wrData;
        REG_CTRL2: ctrl2 <= wrData;
        REG_CTRL3: ctrl3 <= wrData;
        REG_CTRL4: ctrl4 <= wrData;
        REG_CTRL7: ctrl7 <= wrData;
        REG_PERF:  perf  <= wrData;
        REG_GFX:   gfx   <= wrData;
        default:   ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_SMADDR; g++) begin : g_smaddr
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (strb.wrEn && strb.sel == REG_SMADDR && strb.sub == 2'(g)) q <= wrData;
    end
    assign smAddr[g] = q;
  end

  for (genvar g = 0; g < NUM_HDR; g++) begin : g_hdr
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (strb.wrEn && strb.sel == REG_HDR && strb.sub == 2'(g)) q <= wrData;
    end
    assign hdr[g] = q;
  end

  always_comb begin
    selVal = '0;
    case (strb.sel)
      REG_CTRL1:  selVal = ctrl1;
      REG_CTRL2:  selVal = ctrl2;
      REG_CTRL3:  selVal = ctrl3;
      REG_CTRL4:  selVal = ctrl4;
      REG_CTRL7:  selVal = ctrl7;
      REG_PERF:   selVal = perf;
      REG_GFX:    selVal = gfx;
      REG_ID0:    selVal = ID0_VALUE;
      REG_ID1:    selVal = DEV_ID1;
      REG_SMADDR: if (int'(strb.sub) < NUM_SMADDR) selVal = smAddr[strb.sub];
      REG_HDR:    selVal = hdr[strb.sub];
      default:    selVal = '0;
    endcase
  end

  assign rdData  = strb.rdEn ? selVal : '0;
  assign mapEn   = ctrl3[MAPEN_BIT];
  assign lockBit = ctrl3[LOCK_BIT];

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfg_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int unsigned INDEX_PORT = 'h22,
  parameter int unsigned DATA_PORT  = 'h23,
  parameter logic [7:0]  DEV_ID1    = 8'h2A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic [7:0]        ioWrData,
  input  logic              privMode,
  output logic [7:0]        ioRdData,
  output logic              ioClaim
);

  strobe_t strb;
  logic    mapEn;
  logic    lockBit;

  cfg_port_ctrl #(
    .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ioWrData(ioWrData), .privMode(privMode), .mapEn(mapEn),
    .lockBit(lockBit), .ioClaim(ioClaim), .strb(strb)
  );

  cfg_reg_bank #(.DEV_ID1(DEV_ID1)) u_bank (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(ioWrData),
    .rdData(ioRdData), .mapEn(mapEn), .lockBit(lockBit)
  );

endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk #(
  parameter int          ADDR_W     = 16,
  parameter int unsigned INDEX_PORT = 'h22,
  parameter int unsigned DATA_PORT  = 'h23
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioRd,
  input logic              ioWr,
  input logic [7:0]        ioWrData,
  input logic [7:0]        ioRdData,
  input logic              ioClaim,
  input logic              mapEn
);

  logic       isIdx, isData, dataAcc, idxWr;
  logic [7:0] lastIdx;
  logic       haveIdx;

  assign isIdx   = ioAddr == ADDR_W'(INDEX_PORT);
  assign isData  = ioAddr == ADDR_W'(DATA_PORT);
  assign dataAcc = isData && (ioRd || ioWr);
  assign idxWr   = isIdx && ioWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastIdx <= 8'h00;
      haveIdx <= 1'b0;
    end else if (idxWr) begin
      lastIdx <= ioWrData;
      haveIdx <= 1'b1;
    end else if (dataAcc) begin
      haveIdx <= 1'b0;
    end
  end

  assert_spent_index_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && !haveIdx) |-> !ioClaim);

  assert_back_to_back_R3: assert property (@(posedge clk) disable iff (!rstN)
    dataAcc |=> !(dataAcc && ioClaim));

  assert_foreign_addr_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((ioRd || ioWr) && !isIdx && !isData) |-> !ioClaim);

  assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(ioRd && ioClaim) |-> (ioRdData == 8'h00));

  assert_id0_const_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && ioRd && ioClaim && lastIdx == 8'hFE) |-> (ioRdData == 8'h40));

  assert_base_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && ioClaim && !mapEn) |-> (lastIdx[7:4] == 4'hC || lastIdx >= 8'hFE));

endmodule

bind cfg_index_port cfg_index_port_chk #(
  .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)
) u_chk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
  .ioWrData(ioWrData), .ioRdData(ioRdData), .ioClaim(ioClaim), .mapEn(mapEn)
);

// File: tb/tb_cfg_index_port.sv
module tb_cfg_index_port;

  localparam logic [7:0] DEVID1 = 8'h2A;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = 16'h0;
  logic        ioRd = 1'b0, ioWr = 1'b0, privMode = 1'b0;
  logic [7:0]  ioWrData = 8'h0;
  logic [7:0]  ioRdData;
  logic        ioClaim;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [256];

  always #10 clk = ~clk;

  cfg_index_port #(.DEV_ID1(DEVID1)) dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ioWrData(ioWrData), .privMode(privMode), .ioRdData(ioRdData), .ioClaim(ioClaim)
  );

  function automatic logic isBase(input logic [7:0] i);
    return (i[7:4] == 4'hC) || (i >= 8'hFE);
  endfunction
  function automatic logic isMapped(input logic [7:0] i);
    return i == 8'hE8 || i == 8'hEB || i == 8'h20 || i == 8'hB8 ||
           (i >= 8'hB0 && i <= 8'hB3);
  endfunction
  function automatic logic mMapEn(); return mdl[8'hC3][4]; endfunction
  function automatic logic mLock();  return mdl[8'hC3][0]; endfunction
  function automatic logic decoded(input logic [7:0] i);
    return isBase(i) || (mMapEn() && isMapped(i));
  endfunction
  function automatic logic writable(input logic [7:0] i);
    return i == 8'hC1 || i == 8'hC2 || i == 8'hC3 || (i >= 8'hCD && i <= 8'hCF) || isMapped(i);
  endfunction
  function automatic logic lockable(input logic [7:0] i);
    return i == 8'hC1 || i == 8'hC3 || (i >= 8'hCD && i <= 8'hCF);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp, input logic [7:0] idx);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s idx=%02h actual=%02h expected=%02h", req, idx, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic rd, input logic wr,
                        input logic [7:0] d, output logic claim, output logic [7:0] q);
    @(negedge clk);
    ioAddr = a; ioRd = rd; ioWr = wr; ioWrData = d;
    #5;
    claim = ioClaim;
    q = ioRdData;
    @(negedge clk);
    ioRd = 1'b0; ioWr = 1'b0;
  endtask

  // index write then data read; checks claim and data, then a spent access
  task automatic readIdx(input logic [7:0] i, input string req);
    logic c; logic [7:0] q;
    access(16'h22, 1'b0, 1'b1, i, c, q);
    chk("R9", {7'b0, c}, {7'b0, mMapEn()}, i);
    access(16'h23, 1'b1, 1'b0, 8'h00, c, q);
    chk(req, {7'b0, c}, {7'b0, decoded(i)}, i);
    chk(req, q, decoded(i) ? mdl[i] : 8'h00, i);
    access(16'h23, 1'b1, 1'b0, 8'h00, c, q);
    chk("R3", {7'b0, c, q[0]}, 8'h00, i);
  endtask

  task automatic writeIdx(input logic [7:0] i, input logic [7:0] d, input string req);
    logic c; logic [7:0] q;
    logic hit;
    hit = decoded(i);
    access(16'h22, 1'b0, 1'b1, i, c, q);
    access(16'h23, 1'b0, 1'b1, d, c, q);
    chk(req, {7'b0, c}, {7'b0, hit}, i);
    if (hit && writable(i) && !(lockable(i) && mLock() && !privMode)) mdl[i] = d;
  endtask

  task automatic sweepRead(input string req);
    for (int i = 0; i < 256; i++) readIdx(8'(i), req);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic c; logic [7:0] q;
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    mdl[8'hE8] = 8'h85;
    mdl[8'h20] = 8'h07;
    mdl[8'hFE] = 8'h40;
    mdl[8'hFF] = DEVID1;

    repeat (3) @(posedge clk);
    #3 rstN = 1'b1;

    // R11 idle state and R3 data access with no index since reset
    #2;
    chk("R11", {7'b0, ioClaim}, 8'h00, 8'h00);
    chk("R11", ioRdData, 8'h00, 8'h00);
    access(16'h23, 1'b1, 1'b0, 8'h00, c, q);
    chk("R3", {7'b0, c}, 8'h00, 8'h00);

    // R1 R4 R8 R10: base set with map enable clear
    sweepRead("R4");

    // enable the map (bit 4 of C3h), R5 R1 widened reads
    writeIdx(8'hC3, 8'h10, "R2");
    sweepRead("R5");

    // R2 R5 R8 R10: write every index except C3h, then read back
    for (int i = 0; i < 256; i++)
      if (i != 'hC3) writeIdx(8'(i), 8'(i) ^ 8'hA5, "R2");
    sweepRead("R2");

    // R6: set the lock, attempt writes
    writeIdx(8'hC3, 8'h11, "R6");
    for (int i = 'hC0; i < 'hD0; i++) writeIdx(8'(i), 8'(i) ^ 8'h3C, "R6");
    writeIdx(8'hC3, 8'h00, "R6");
    for (int i = 'hC0; i < 'hD0; i++) readIdx(8'(i), "R6");
    readIdx(8'hE8, "R6");

    // R7: privileged override
    privMode = 1'b1;
    for (int i = 'hC0; i < 'hD0; i++)
      if (i != 'hC3) writeIdx(8'(i), 8'(i) ^ 8'h77, "R7");
    for (int i = 'hC0; i < 'hD0; i++) readIdx(8'(i), "R7");
    writeIdx(8'hC3, 8'h00, "R7");
    privMode = 1'b0;
    readIdx(8'hC3, "R7");

    // R4 R9 after map enable cleared again
    for (int i = 0; i < 256; i++) readIdx(8'(i), "R4");

    // R8: ID registers ignore writes
    writeIdx(8'hFE, 8'h00, "R8");
    writeIdx(8'hFF, 8'h00, "R8");
    readIdx(8'hFE, "R8");
    readIdx(8'hFF, "R8");

    // R11: foreign addresses and index-port reads
    access(16'h22, 1'b0, 1'b1, 8'hC2, c, q);
    access(16'h0080, 1'b1, 1'b0, 8'h00, c, q);
    chk("R11", {7'b0, c}, 8'h00, 8'hC2);
    chk("R11", q, 8'h00, 8'hC2);
    access(16'h0122, 1'b0, 1'b1, 8'hC1, c, q);
    chk("R11", {7'b0, c}, 8'h00, 8'hC1);
    access(16'h22, 1'b1, 1'b0, 8'h00, c, q);
    chk("R11", {7'b0, c, q[0]}, 8'h00, 8'h22);
    // the index C2h must still be selected and unspent
    access(16'h23, 1'b1, 1'b0, 8'h00, c, q);
    chk("R2", {7'b0, c}, 8'h01, 8'hC2);
    chk("R2", q, mdl[8'hC2], 8'hC2);

    finishRun();
  end

endmodule